// File: doc/BRIEF.md
# Round-Robin Interrupt Dispatcher

This block gathers up to 64 internal interrupt sources. The source count is a parameter set to 32 or 64. The block holds one enable bit per source. A source is pending when its raw status line is high and its enable bit is set.

On each dispatch request the block picks exactly one pending source. It does so in fair rotating order: the search starts at a saved pointer, and after a grant the pointer moves one past the source just served. No source outranks another. The block returns the chosen identifier and a flag that says which identifier space it belongs to.

A contiguous range of source indices can be set aside by parameter as cascaded external lines. A grant from that range is reported in a separate external space, numbered from zero. Software-style single-bit mask and unmask commands change one enable bit at a time. The current enable vector and pending vector can always be read back.

Top module: `rr_irq_dispatch`

## Requirements
- R1: After a synchronous reset, every enable bit is 0, the search pointer is 0, `gnt` is 0, `gnt_id` is 0 and both read-back vectors are 0.
- R2: `rd_pend` shows, one cycle after sampling, the bitwise AND of `raw_stat` and the enable vector as it stood in the sampled cycle.
- R3: A request made while nothing is pending gives `gnt`=0 in the next cycle and leaves the search pointer unchanged.
- R4: A request sampled at a clock edge while something is pending gives `gnt`=1 in the following cycle. The chosen source is the first pending index found by searching upward from the pointer, wrapping from NSRC-1 to 0.
- R5: After a grant for index i, the pointer becomes (i+1) modulo NSRC, so the next search starts just past i.
- R6: When CASC_EN is 1 and the served index i satisfies CASC_LO <= i <= CASC_HI, `gnt_ext`=1 and `gnt_id`=i-CASC_LO. Otherwise `gnt_ext`=0 and `gnt_id`=i. Without a grant, `gnt_id` and `gnt_ext` are 0.
- R7: `msk_set` sets only enable bit `msk_idx`, and `msk_clr` clears only that bit. When both are high, the clear wins. The change shows on `rd_mask` and in pending from the next cycle.
- R8: Each sampled request yields at most one grant, and `gnt` is never high in a cycle that did not follow a sampled request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_stat | input | NSRC | Raw status line per source |
| msk_set | input | 1 | Set enable bit `msk_idx` |
| msk_clr | input | 1 | Clear enable bit `msk_idx` (wins over set) |
| msk_idx | input | IDW | Source index for mask command |
| req | input | 1 | Dispatch request |
| gnt | output | 1 | Registered grant for the previous cycle's request |
| gnt_id | output | IDW | Served identifier (internal index or external number) |
| gnt_ext | output | 1 | 1 when `gnt_id` is in the external space |
| rd_mask | output | NSRC | Current enable vector |
| rd_pend | output | NSRC | Registered pending vector |

## Verification
The bench goes after wrap-around from index 63 back to low indices. A design with a wrong modulo or shift would skip or repeat sources there. It also checks that an empty request leaves the pointer alone; a design that advances anyway would serve out of order on the next request. Grants at both ends of the cascaded range test the boundary compare and the subtraction, which catch off-by-one remaps. A simultaneous set and clear on one index exposes a wrong command priority, and random mask traffic would reveal a command that disturbs neighbouring enable bits.

// File: rtl/rrd_pkg.sv
package rrd_pkg;
  typedef enum logic {SPACE_INT = 1'b0, SPACE_EXT = 1'b1} id_space_e;
endpackage

// File: rtl/rrd_mask_reg.sv
module rrd_mask_reg #(
  parameter int NSRC = 64,
  parameter int IDW  = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            set_i,
  input  logic            clr_i,
  input  logic [IDW-1:0]  idx_i,
  output logic [NSRC-1:0] mask_o
);
  always_ff @(posedge clk) begin
    if (rst)        mask_o <= '0;
    else if (clr_i) mask_o[idx_i] <= 1'b0;
    else if (set_i) mask_o[idx_i] <= 1'b1;
  end

  // R7: a command touches at most one enable bit
  p_one_bit_r7: assert property (@(posedge clk) disable iff (rst)
    (set_i || clr_i) |=> ($countones(mask_o ^ $past(mask_o)) <= 1));
  // R7: no command, no change
  p_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !(set_i || clr_i) |=> $stable(mask_o));
  // R7: clear takes precedence
  p_clr_wins_r7: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !mask_o[$past(idx_i)]);
endmodule

// File: rtl/rrd_rr_pick.sv
module rrd_rr_pick #(
  parameter int NSRC = 64,
  parameter int IDW  = $clog2(NSRC)
) (
  input  logic [NSRC-1:0] pend_i,
  input  logic [IDW-1:0]  ptr_i,
  output logic            any_o,
  output logic [IDW-1:0]  idx_o
);
  logic [2*NSRC-1:0] dbl;
  logic [NSRC-1:0]   rot;
  logic [IDW-1:0]    off;

  assign dbl   = {pend_i, pend_i} >> ptr_i;
  assign rot   = dbl[NSRC-1:0];
  assign any_o = |pend_i;

  always_comb begin
    off = '0;
    for (int k = NSRC - 1; k >= 0; k--) begin
      if (rot[k]) off = IDW'(k);
    end
  end

  assign idx_o = ptr_i + off;
endmodule

// File: rtl/rrd_id_map.sv
module rrd_id_map
  import rrd_pkg::*;
#(
  parameter int NSRC    = 64,
  parameter int IDW     = $clog2(NSRC),
  parameter bit CASC_EN = 1'b1,
  parameter int CASC_LO = 40,
  parameter int CASC_HI = 45
) (
  input  logic [IDW-1:0] idx_i,
  output logic [IDW-1:0] id_o,
  output id_space_e      space_o
);
  generate
    if (CASC_EN) begin : g_casc
      localparam logic [IDW-1:0] LO = IDW'(CASC_LO);
      localparam logic [IDW-1:0] HI = IDW'(CASC_HI);
      logic in_rng;
      assign in_rng  = (idx_i >= LO) && (idx_i <= HI);
      assign id_o    = in_rng ? (idx_i - LO) : idx_i;
      assign space_o = in_rng ? SPACE_EXT : SPACE_INT;
    end else begin : g_flat
      assign id_o    = idx_i;
      assign space_o = SPACE_INT;
    end
  endgenerate
endmodule

// File: rtl/rr_irq_dispatch.sv
module rr_irq_dispatch
  import rrd_pkg::*;
#(
  parameter int NSRC    = 64,
  parameter bit CASC_EN = 1'b1,
  parameter int CASC_LO = 40,
  parameter int CASC_HI = 45,
  localparam int IDW    = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] raw_stat,
  input  logic            msk_set,
  input  logic            msk_clr,
  input  logic [IDW-1:0]  msk_idx,
  input  logic            req,
  output logic            gnt,
  output logic [IDW-1:0]  gnt_id,
  output logic            gnt_ext,
  output logic [NSRC-1:0] rd_mask,
  output logic [NSRC-1:0] rd_pend
);
  logic [NSRC-1:0] mask_q;
  logic [NSRC-1:0] pend;
  logic [IDW-1:0]  ptr_q;
  logic            any;
  logic [IDW-1:0]  pick_idx;
  logic [IDW-1:0]  map_id;
  id_space_e       map_space;

  rrd_mask_reg #(.NSRC(NSRC), .IDW(IDW)) u_mask (
    .clk(clk), .rst(rst), .set_i(msk_set), .clr_i(msk_clr),
    .idx_i(msk_idx), .mask_o(mask_q)
  );

  assign pend = raw_stat & mask_q;

  rrd_rr_pick #(.NSRC(NSRC), .IDW(IDW)) u_pick (
    .pend_i(pend), .ptr_i(ptr_q), .any_o(any), .idx_o(pick_idx)
  );

  rrd_id_map #(.NSRC(NSRC), .IDW(IDW), .CASC_EN(CASC_EN),
               .CASC_LO(CASC_LO), .CASC_HI(CASC_HI)) u_map (
    .idx_i(pick_idx), .id_o(map_id), .space_o(map_space)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q   <= '0;
      gnt     <= 1'b0;
      gnt_id  <= '0;
      gnt_ext <= 1'b0;
      rd_pend <= '0;
    end else begin
      rd_pend <= pend;
      if (req && any) begin
        ptr_q   <= pick_idx + 1'b1;
        gnt     <= 1'b1;
        gnt_id  <= map_id;
        gnt_ext <= (map_space == SPACE_EXT);
      end else begin
        gnt     <= 1'b0;
        gnt_id  <= '0;
        gnt_ext <= 1'b0;
      end
    end
  end

  assign rd_mask = mask_q;

  // R4: the encoder always lands on a pending source
  p_pick_pending_r4: assert property (@(posedge clk) disable iff (rst)
    any |-> pend[pick_idx]);
  // R3: empty request keeps the pointer
  p_idle_ptr_r3: assert property (@(posedge clk) disable iff (rst)
    (req && !any) |=> $stable(ptr_q));
  // R5: pointer lands one past the served index
  p_ptr_adv_r5: assert property (@(posedge clk) disable iff (rst)
    (req && any) |=> (ptr_q == IDW'($past(pick_idx) + 1'b1)));
  // R8: a grant only follows a request
  p_gnt_cause_r8: assert property (@(posedge clk) disable iff (rst)
    gnt |-> $past(req));
  // R6: external identifiers stay inside the cascaded span
  p_ext_bound_r6: assert property (@(posedge clk) disable iff (rst)
    gnt_ext |-> (gnt && (gnt_id <= IDW'(CASC_HI - CASC_LO))));
endmodule

// File: tb/test_rr_irq_dispatch.sv
module test_rr_irq_dispatch;
  localparam int  CLK_P = 10;
  localparam int  NSRC  = 64;
  localparam int  IDW   = 6;
  localparam int  LO    = 40;
  localparam int  HI    = 45;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NSRC-1:0] raw_stat = '0;
  logic            msk_set = 1'b0, msk_clr = 1'b0, req = 1'b0;
  logic [IDW-1:0]  msk_idx = '0;
  logic            gnt, gnt_ext;
  logic [IDW-1:0]  gnt_id;
  logic [NSRC-1:0] rd_mask, rd_pend;

  int total = 0, bad = 0;
  bit done = 1'b0;

  logic [NSRC-1:0] m_mask = '0;
  logic [IDW-1:0]  m_ptr = '0;
  logic            e_gnt = 1'b0, e_ext = 1'b0;
  logic [IDW-1:0]  e_id = '0;
  logic [NSRC-1:0] e_pend = '0;

  always #(CLK_P/2) clk = ~clk;

  rr_irq_dispatch #(.NSRC(NSRC), .CASC_EN(1'b1), .CASC_LO(LO), .CASC_HI(HI))
  i_rr_irq_dispatch (
    .clk(clk), .rst(rst), .raw_stat(raw_stat), .msk_set(msk_set),
    .msk_clr(msk_clr), .msk_idx(msk_idx), .req(req), .gnt(gnt),
    .gnt_id(gnt_id), .gnt_ext(gnt_ext), .rd_mask(rd_mask), .rd_pend(rd_pend)
  );

  function automatic int pick(input logic [NSRC-1:0] p, input int start);
    for (int k = 0; k < NSRC; k++) begin
      if (p[(start + k) % NSRC]) return (start + k) % NSRC;
    end
    return -1;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Apply one cycle of stimulus at negedge, predict, then check next negedge.
  task automatic step(input logic [NSRC-1:0] raw, input logic s, input logic c,
                      input int idx, input logic r);
    logic [NSRC-1:0] p;
    int i;
    raw_stat = raw; msk_set = s; msk_clr = c; msk_idx = IDW'(idx); req = r;
    p = raw & m_mask;
    e_pend = p;
    if (r && (p != '0)) begin
      i = pick(p, int'(m_ptr));
      e_gnt = 1'b1;
      e_ext = (i >= LO) && (i <= HI);
      e_id  = e_ext ? IDW'(i - LO) : IDW'(i);
      m_ptr = IDW'(i + 1);
    end else begin
      e_gnt = 1'b0; e_ext = 1'b0; e_id = '0;
    end
    if (c)      m_mask[idx] = 1'b0;
    else if (s) m_mask[idx] = 1'b1;
    @(negedge clk);
    chk("R8 R4 gnt", 64'(gnt), 64'(e_gnt));
    chk("R4 R5 gnt_id", 64'(gnt_id), 64'(e_id));
    chk("R6 gnt_ext", 64'(gnt_ext), 64'(e_ext));
    chk("R7 rd_mask", rd_mask, m_mask);
    chk("R2 rd_pend", rd_pend, e_pend);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00c0ffee));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 gnt", 64'(gnt), 64'd0);
    chk("R1 gnt_id", 64'(gnt_id), 64'd0);
    chk("R1 rd_mask", rd_mask, 64'd0);
    chk("R1 rd_pend", rd_pend, 64'd0);

    // R3: request with nothing enabled
    step('1, 0, 0, 0, 1);
    // R7: enable 5, 40, 45, 63, 2
    step('0, 1, 0, 5, 0);
    step('0, 1, 0, 40, 0);
    step('0, 1, 0, 45, 0);
    step('0, 1, 0, 63, 0);
    step('0, 1, 0, 2, 0);
    // R3: enabled but raw low, pointer must stay at 0
    step('0, 0, 0, 0, 1);
    // R4 R5 R6: rotating order 2,5,40(ext0),45(ext5),63, wrap to 2
    repeat (7) step('1, 0, 0, 0, 1);
    // R7: set and clear together, clear wins
    step('1, 1, 1, 5, 0);
    step('1, 0, 0, 0, 1);
    step('1, 0, 0, 0, 1);

    // random mixture
    for (int n = 0; n < 3000; n++) begin
      logic [NSRC-1:0] raw;
      raw = {$urandom, $urandom};
      if ($urandom % 3 == 0) raw = raw & {$urandom, $urandom};
      step(raw, ($urandom % 2) == 0, ($urandom % 4) == 0,
           int'($urandom % NSRC), ($urandom % 5) < 3);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule